// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

This block is an 8-bit synchronous up-counter built from two 4-bit stages. Both stages run on one clock and share a synchronous clear, a synchronous preset load and a local count enable. A chain enable passes from stage to stage through each stage's terminal-count carry. As a result, the upper nibble advances only on an edge where the lower nibble sits at 15 and may count. The pair forms a modulus-256 counter, and its carry output can drive a further stage or serve as a divide-by-256 strobe.

A decoder compares the full count with a parameterised value, which defaults to 5. It drives an active-low match flag. The preset bus loads any starting value, so the same block works as a programmable divider. Load with 256 minus N to get a carry after N enabled clocks.

Top module: `cascade_prescaler`

## Requirements
- R1: When `clearN` is low at a rising edge, `countValue` becomes 0 after that edge. This happens whatever `loadN`, the enables and `presetData` are doing.
- R2: When `clearN` is high and `loadN` is low at a rising edge, `countValue` takes `presetData` after that edge, even when both enables are low.
- R3: When `clearN` and `loadN` are high and both `enableLocal` and `enableChain` are high, each rising edge adds one to `countValue`, modulo 256.
- R4: When `clearN` and `loadN` are high and either enable is low, `countValue` keeps its value across the edge.
- R5: Bits [3:0] form the low stage and bits [7:4] form the high stage. The low stage wraps from 15 to 0, and the high stage advances by one on exactly that edge.
- R6: `carryOut` is high exactly when `countValue` is 255 and `enableChain` is high. It is combinational from those two inputs.
- R7: With both enables held high from a count of 0, `carryOut` is high for exactly one cycle in each 256 clocks, and the count returns to 0 after the 256th edge.
- R8: `matchN` is low exactly when `countValue` equals MATCH_VALUE (default 5, binary 00000101) and is high for every other count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for every stage |
| clearN | input | 1 | Synchronous clear, active low, highest priority |
| loadN | input | 1 | Synchronous preset load, active low |
| enableLocal | input | 1 | Count enable shared by all stages; does not gate the carry |
| enableChain | input | 1 | Count enable of the lowest stage; gates the carry |
| presetData | input | 8 | Value loaded when the load is active |
| countValue | output | 8 | Current count, low stage in bits [3:0] |
| carryOut | output | 1 | Terminal-count carry of the top stage |
| matchN | output | 1 | Active-low flag for count equal to MATCH_VALUE |

## Verification
A reference model steps on every edge. Directed cases cover several situations:
- a clear with a load and both enables active, which tells clear priority from load priority;
- a load while the enables are off, which tells load from counting;
- a count across 0x0F and 0xFF, which shows whether the nibble carry and the top wrap are correct;
- disabling each enable alone, which separates their roles. At a count of 255, `enableChain` also gates the carry.

A full 256-clock run counts carry pulses to confirm the modulus. After that, seeded random mixes of clear, load and enable patterns test the priority order against the model in every combination.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int STAGE_W_DEFAULT = 4;

  typedef struct packed {
    logic clear;
    logic load;
    logic step;
    logic carryGate;
  } stageStrobes_t;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic          clearN,
  input  logic          loadN,
  input  logic          enableLocal,
  input  logic          enableChain,
  output stageStrobes_t strobes
);
  always_comb begin
    strobes.clear     = ~clearN;
    strobes.load      = clearN & ~loadN;
    strobes.step      = clearN & loadN & enableLocal & enableChain;
    strobes.carryGate = enableChain;
  end
endmodule

// File: rtl/cnt_datapath.sv
module cnt_datapath
  import cnt_pkg::*;
#(
  parameter int WIDTH = STAGE_W_DEFAULT
) (
  input  logic             clk,
  input  stageStrobes_t    strobes,
  input  logic [WIDTH-1:0] presetSlice,
  output logic [WIDTH-1:0] countSlice,
  output logic             carry
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] countReg;
  logic             termHit;

  always_ff @(posedge clk) begin
    if (strobes.clear)      countReg <= '0;
    else if (strobes.load)  countReg <= presetSlice;
    else if (strobes.step)  countReg <= countReg + ONE;
  end

  assign termHit    = &countReg;
  assign carry      = termHit & strobes.carryGate;
  assign countSlice = countReg;
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int WIDTH = STAGE_W_DEFAULT
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             enableLocal,
  input  logic             enableChain,
  input  logic [WIDTH-1:0] presetSlice,
  output logic [WIDTH-1:0] countSlice,
  output logic             carry
);
  stageStrobes_t strobes;

  cnt_ctrl u_ctrl (
    .clearN      (clearN),
    .loadN       (loadN),
    .enableLocal (enableLocal),
    .enableChain (enableChain),
    .strobes     (strobes)
  );

  cnt_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .strobes     (strobes),
    .presetSlice (presetSlice),
    .countSlice  (countSlice),
    .carry       (carry)
  );
endmodule

// File: rtl/cnt_match_decode.sv
module cnt_match_decode #(
  parameter int WIDTH = 8,
  parameter int MATCH_VALUE = 5
) (
  input  logic [WIDTH-1:0] countIn,
  output logic             matchN
);
  localparam logic [WIDTH-1:0] MATCH_CODE = WIDTH'(MATCH_VALUE);

  logic [WIDTH-1:0] bitDiff;

  always_comb begin
    bitDiff = countIn ^ MATCH_CODE;
    matchN  = |bitDiff;
  end
endmodule

// File: rtl/cascade_prescaler.sv
module cascade_prescaler
  import cnt_pkg::*;
#(
  parameter int STAGE_W     = STAGE_W_DEFAULT,
  parameter int STAGES      = 2,
  parameter int MATCH_VALUE = 5,
  localparam int TOTAL_W    = STAGE_W * STAGES
) (
  input  logic               clk,
  input  logic               clearN,
  input  logic               loadN,
  input  logic               enableLocal,
  input  logic               enableChain,
  input  logic [TOTAL_W-1:0] presetData,
  output logic [TOTAL_W-1:0] countValue,
  output logic               carryOut,
  output logic               matchN
);
  logic [STAGES:0] chainEn;

  assign chainEn[0] = enableChain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    cnt_stage #(.WIDTH(STAGE_W)) u_stage (
      .clk         (clk),
      .clearN      (clearN),
      .loadN       (loadN),
      .enableLocal (enableLocal),
      .enableChain (chainEn[s]),
      .presetSlice (presetData[s*STAGE_W +: STAGE_W]),
      .countSlice  (countValue[s*STAGE_W +: STAGE_W]),
      .carry       (chainEn[s+1])
    );
  end

  assign carryOut = chainEn[STAGES];

  cnt_match_decode #(.WIDTH(TOTAL_W), .MATCH_VALUE(MATCH_VALUE)) u_match (
    .countIn (countValue),
    .matchN  (matchN)
  );
endmodule

// File: rtl/cascade_prescaler_checker.sv
module cascade_prescaler_checker #(
  parameter int TOTAL_W = 8,
  parameter int MATCH_VALUE = 5
) (
  input logic               clk,
  input logic               clearN,
  input logic               loadN,
  input logic               enableLocal,
  input logic               enableChain,
  input logic [TOTAL_W-1:0] presetData,
  input logic [TOTAL_W-1:0] countValue,
  input logic               carryOut,
  input logic               matchN
);
  localparam logic [TOTAL_W-1:0] ONE = {{(TOTAL_W-1){1'b0}}, 1'b1};
  localparam logic [TOTAL_W-1:0] MATCH_CODE = TOTAL_W'(MATCH_VALUE);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clearN) armed <= 1'b1;

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!armed)
    !clearN |=> countValue == '0);

  assert_load_preset_R2: assert property (@(posedge clk) disable iff (!armed)
    (clearN && !loadN) |=> countValue == $past(presetData));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!armed)
    (clearN && loadN && enableLocal && enableChain) |=> countValue == $past(countValue) + ONE);

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!armed)
    (clearN && loadN && !(enableLocal && enableChain)) |=> $stable(countValue));

  assert_carry_only_at_top_R6: assert property (@(posedge clk) disable iff (!armed)
    carryOut |-> (countValue == '1 && enableChain));

  assert_carry_present_R6: assert property (@(posedge clk) disable iff (!armed)
    (countValue == '1 && enableChain) |-> carryOut);

  assert_match_flag_R8: assert property (@(posedge clk) disable iff (!armed)
    !matchN |-> countValue == MATCH_CODE);

  assert_match_present_R8: assert property (@(posedge clk) disable iff (!armed)
    countValue == MATCH_CODE |-> !matchN);
endmodule

bind cascade_prescaler cascade_prescaler_checker #(
  .TOTAL_W     (TOTAL_W),
  .MATCH_VALUE (MATCH_VALUE)
) u_checker (
  .clk         (clk),
  .clearN      (clearN),
  .loadN       (loadN),
  .enableLocal (enableLocal),
  .enableChain (enableChain),
  .presetData  (presetData),
  .countValue  (countValue),
  .carryOut    (carryOut),
  .matchN      (matchN)
);

// File: tb/test_cascade_prescaler.sv
`timescale 1ns/1ps
module test_cascade_prescaler;
  logic       clk = 1'b0;
  logic       clearN = 1'b1;
  logic       loadN = 1'b1;
  logic       enableLocal = 1'b0;
  logic       enableChain = 1'b0;
  logic [7:0] presetData = 8'h00;
  logic [7:0] countValue;
  logic       carryOut;
  logic       matchN;

  int vecCount = 0;
  int failCount = 0;
  logic [7:0] model = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_prescaler i_cascade_prescaler (
    .clk         (clk),
    .clearN      (clearN),
    .loadN       (loadN),
    .enableLocal (enableLocal),
    .enableChain (enableChain),
    .presetData  (presetData),
    .countValue  (countValue),
    .carryOut    (carryOut),
    .matchN      (matchN)
  );

  function automatic logic [7:0] nextCount(logic [7:0] cur, logic cN, logic lN,
                                           logic eL, logic eC, logic [7:0] d);
    if (!cN)            return 8'h00;
    else if (!lN)       return d;
    else if (eL && eC)  return cur + 8'h01;
    else                return cur;
  endfunction

  function automatic logic expCarry(logic [7:0] cur, logic eC);
    return (cur == 8'hFF) && eC;
  endfunction

  function automatic logic expMatchN(logic [7:0] cur);
    return cur != 8'd5;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, check combinational outputs, then the count after the edge.
  task automatic applyVec(logic cN, logic lN, logic eL, logic eC, logic [7:0] d,
                          string tag, bit checkComb);
    @(negedge clk);
    clearN = cN; loadN = lN; enableLocal = eL; enableChain = eC; presetData = d;
    #1;
    if (checkComb) begin
      check("R6 carry", {7'd0, carryOut}, {7'd0, expCarry(model, eC)});
      check("R8 match", {7'd0, matchN}, {7'd0, expMatchN(model)});
    end
    @(posedge clk);
    model = nextCount(model, cN, lN, eL, eC, d);
    #1;
    check(tag, countValue, model);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    int pulses;
    void'($urandom(32'd7321));

    // R1: clear beats load and counting
    applyVec(1'b0, 1'b0, 1'b1, 1'b1, 8'hC3, "R1 clear priority", 1'b0);
    applyVec(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R1 clear held", 1'b1);

    // R2: load with both enables low
    applyVec(1'b1, 1'b0, 1'b0, 1'b0, 8'hA7, "R2 load idle enables", 1'b1);
    // R4: each enable low alone holds
    applyVec(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R4 local low hold", 1'b1);
    applyVec(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4 chain low hold", 1'b1);
    // R3: counting
    applyVec(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R3 step", 1'b1);
    applyVec(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R3 step", 1'b1);
    // R2: load mid-count takes effect on next edge
    applyVec(1'b1, 1'b0, 1'b1, 1'b1, 8'h0E, "R2 load mid count", 1'b1);
    // R5: nibble boundary 0x0E -> 0x0F -> 0x10
    applyVec(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R5 to 0F", 1'b1);
    applyVec(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R5 nibble carry", 1'b1);
    // R5: nibble at 15 with local enable low: no advance
    applyVec(1'b1, 1'b0, 1'b0, 1'b0, 8'h2F, "R2 load 2F", 1'b1);
    applyVec(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R5 hold at 2F", 1'b1);
    applyVec(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R5 2F to 30", 1'b1);
    // R6: carry at 255 gated by chain enable
    applyVec(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, "R2 load FF", 1'b1);
    applyVec(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R6 FF chain low", 1'b1);
    applyVec(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R6 FF local low", 1'b1);
    applyVec(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R3 wrap FF to 00", 1'b1);
    // R8: step through 4, 5, 6
    applyVec(1'b1, 1'b0, 1'b0, 1'b0, 8'h04, "R2 load 04", 1'b1);
    applyVec(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R8 reach 5", 1'b1);
    applyVec(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R8 leave 5", 1'b1);
    applyVec(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R8 past 5", 1'b1);

    // R7: one carry pulse per 256 enabled clocks
    applyVec(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R1 clear before run", 1'b1);
    pulses = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      clearN = 1'b1; loadN = 1'b1; enableLocal = 1'b1; enableChain = 1'b1;
      #1;
      if (carryOut) pulses++;
      @(posedge clk);
      model = model + 8'h01;
      #1;
    end
    check("R7 pulse count", 8'(pulses), 8'd1);
    check("R7 back to zero", countValue, 8'h00);

    // Random mix against the model
    for (int k = 0; k < 3000; k++) begin
      logic cN, lN, eL, eC;
      logic [7:0] d;
      string tag;
      cN = ($urandom % 32) != 0;
      lN = ($urandom % 16) != 0;
      eL = ($urandom % 4) != 0;
      eC = ($urandom % 4) != 0;
      d  = 8'($urandom);
      if (!cN)            tag = "R1 random clear";
      else if (!lN)       tag = "R2 random load";
      else if (eL && eC)  tag = "R3 random step";
      else                tag = "R4 random hold";
      applyVec(cN, lN, eL, eC, d, tag, 1'b1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule